// File: doc/BRIEF.md
# Periodic DAC Waveform Sender

This block sits on the host side of a serial DAC link. It builds a 16-bit command word at a steady rate and shifts it out over a four-line frame-sync serial link. The lines are an active-low chip select, an active-low frame sync, a serial clock and serial data. A free-running tick timer sets the sample rate. Each served tick sends one sample. In ramp mode the sample is the next step of a sawtooth. In table mode it is the next entry of a 32-point sine wave that the block computes internally.

A four-bit control nibble fills the top of every word. The receiving converter reads it as its speed and power-down controls. The stored waveform state never holds these bits. The serial clock comes from the system clock through a programmable divider. A tick that arrives while a frame is still going out is held and served as soon as that frame ends. A one-cycle pulse marks the end of each frame.

Top module: `wavefeed_ser`

## Requirements
- R1: While reset is held and right after it, `cs_n`, `fs` and `sck` are high and `frame_done` is low. The first ramp frame after reset carries code 0x004 and the first table frame carries entry 0 (0x800).
- R2: The tick timer fires once every `tick_period`+1 clock cycles. When a frame is shorter than that, successive falling edges of `cs_n` are exactly `tick_period`+1 cycles apart.
- R3: With `wave_sel`=0 each frame carries in bits 11..0 the previous ramp code plus 4, reduced modulo 4096. Bits 1..0 are always zero and 0xFFC is followed by 0x000, which gives 1024 distinct codes per ramp period.
- R4: With `wave_sel`=1 each frame carries the table entry at the current pointer, and the pointer then moves on by one and wraps from 31 to 0. Entry i is 2048 + A(i) for i in 0..16 and 2048 − A(i−16) for i in 17..31. Here A(k) = 4·round(511·|sin(k·π/16)|), which gives 0, 400, 784, 1136, 1444, 1700, 1888, 2004, 2044 for k = 0..8, mirrored about k = 8.
- R5: Bits 15..12 of every word equal `ctrl_nib`. `ctrl_nib`, `wave_sel` and `sck_div` are sampled in the cycle the frame is launched.
- R6: `cs_n` falls one phase before `fs` falls. `fs` rises one phase after the last serial-clock rising edge, and `cs_n` rises one phase after that. `fs` is never low while `cs_n` is high.
- R7: The word goes out MSB first, with exactly 16 falling edges of `sck` while `fs` is low. `sdo` changes only while `sck` is high, so it is stable across every falling edge.
- R8: Every phase lasts H = max(`sck_div`,1) clock cycles, so `cs_n` stays low for exactly 35·H cycles per frame. `sck` idles high.
- R9: A tick that arrives during a frame is served right after that frame, with `cs_n` high for exactly one cycle between the frames. Several ticks during one frame are merged into one, so no sample is skipped.
- R10: `frame_done` is a single-cycle pulse. It is asserted in the first cycle that `cs_n` is high again after a frame.
- R11: The ramp code and the table pointer each advance only on frames of their own mode. Switching modes resumes each one where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_period | input | PER_W | Tick interval minus one, in clock cycles |
| wave_sel | input | 1 | 0 = sawtooth ramp, 1 = sine table |
| ctrl_nib | input | 4 | Control bits placed in word bits 15..12 |
| sck_div | input | DIV_W | Clock cycles per serial-clock phase (0 acts as 1) |
| cs_n | output | 1 | Chip select, active low |
| fs | output | 1 | Frame sync, active low during the 16 data bits |
| sck | output | 1 | Serial clock, idles high, data sampled on falling edge |
| sdo | output | 1 | Serial data, MSB first |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The bench builds the block with its default parameters: a 16-bit tick period and an 8-bit divider. It then varies the period and the divider through the ports. A divider of 0 and 1 gives 35-cycle frames, which makes a full ramp wrap of 1024 frames short enough to run completely. Periods shorter than a frame force the held-tick path, and periods longer than a frame expose the exact timer interval. Divider values up to 5 show that the phase length scales the whole frame.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int WORD_W    = 16;
  localparam int CODE_W    = 12;
  localparam int NIB_W     = WORD_W - CODE_W;
  localparam int TBL_AW    = 5;
  localparam int RAMP_STEP = 4;
  localparam int MID_CODE  = 2048;

  typedef enum logic [2:0] {
    FR_IDLE, FR_CSL, FR_FSL, FR_LO, FR_HI, FR_TAIL
  } fr_state_e;

  // next sawtooth code: add the step, keep the two LSBs clear
  function automatic logic [CODE_W-1:0] ramp_next(input logic [CODE_W-1:0] c);
    return (c + CODE_W'(RAMP_STEP)) & ~CODE_W'(RAMP_STEP - 1);
  endfunction

  // quarter-wave amplitude, already scaled by 4
  function automatic logic [CODE_W-1:0] quarter_amp(input logic [3:0] k);
    case (k)
      4'd0: return 12'd0;
      4'd1: return 12'd400;
      4'd2: return 12'd784;
      4'd3: return 12'd1136;
      4'd4: return 12'd1444;
      4'd5: return 12'd1700;
      4'd6: return 12'd1888;
      4'd7: return 12'd2004;
      default: return 12'd2044;
    endcase
  endfunction

  // full-period sine sample built from quarter-wave symmetry
  function automatic logic [CODE_W-1:0] sine_entry(input logic [TBL_AW-1:0] idx);
    int ii;
    int k;
    logic neg;
    ii = int'(idx);
    neg = (ii > 16);
    if (ii <= 8)       k = ii;
    else if (ii <= 16) k = 16 - ii;
    else if (ii <= 24) k = ii - 16;
    else               k = 32 - ii;
    if (neg) return CODE_W'(MID_CODE - int'(quarter_amp(4'(k))));
    return CODE_W'(MID_CODE + int'(quarter_amp(4'(k))));
  endfunction

  function automatic logic [WORD_W-1:0] word_build(input logic [NIB_W-1:0] nib,
                                                   input logic [CODE_W-1:0] code);
    return {nib, code};
  endfunction
endpackage

// File: rtl/wf_tick_timer.sv
module wf_tick_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;

  assign tick = (cnt_q >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R2: after a tick the timer restarts, so no tick follows unless period is 0
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || period == '0));
endmodule

// File: rtl/wf_sample_gen.sv
module wf_sample_gen
  import wf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              sel,
  input  logic [NIB_W-1:0]  nib,
  output logic [WORD_W-1:0] word
);
  logic [CODE_W-1:0] ramp_q;
  logic [TBL_AW-1:0] ptr_q;
  logic [CODE_W-1:0] code_now;

  assign code_now = sel ? sine_entry(ptr_q) : ramp_next(ramp_q);
  assign word     = word_build(nib, code_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      ptr_q  <= '0;
    end else if (adv) begin
      if (sel) ptr_q  <= ptr_q + 1'b1;
      else     ramp_q <= ramp_next(ramp_q);
    end
  end

  // R3: one ramp frame moves the stored code by exactly 4 (modulo 4096)
  a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sel) |=> ramp_q == $past(ramp_q) + 12'd4);
  // R4: table pointer wraps from the last entry to the first
  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sel && ptr_q == '1) |=> ptr_q == '0);
  // R11: each mode leaves the other mode's state untouched
  a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sel) |=> $stable(ptr_q));
  a_r11_ramp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sel) |=> $stable(ramp_q));
endmodule

// File: rtl/wf_frame_shifter.sv
module wf_frame_shifter
  import wf_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  input  logic [DIV_W-1:0]  div,
  output logic              cs_n,
  output logic              fs,
  output logic              sck,
  output logic              sdo,
  output logic              done,
  output logic              busy
);
  localparam int BIT_CW = $clog2(WORD_W);

  fr_state_e         st_q;
  logic [WORD_W-1:0] sh_q;
  logic [DIV_W-1:0]  half_q;
  logic [DIV_W-1:0]  hc_q;
  logic [BIT_CW-1:0] bcnt_q;
  logic              done_q;
  logic              phase_end;

  assign phase_end = (hc_q == DIV_W'(half_q - 1'b1));
  assign busy      = (st_q != FR_IDLE);
  assign cs_n      = (st_q == FR_IDLE);
  assign fs        = !(st_q == FR_FSL || st_q == FR_LO || st_q == FR_HI);
  assign sck       = (st_q != FR_LO);
  assign sdo       = sh_q[WORD_W-1];
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      sh_q   <= '0;
      half_q <= DIV_W'(1);
      hc_q   <= '0;
      bcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == FR_IDLE) begin
        if (start) begin
          st_q   <= FR_CSL;
          sh_q   <= word_in;
          half_q <= (div == '0) ? DIV_W'(1) : div;
          hc_q   <= '0;
          bcnt_q <= '0;
        end
      end else if (!phase_end) begin
        hc_q <= hc_q + 1'b1;
      end else begin
        hc_q <= '0;
        case (st_q)
          FR_CSL: st_q <= FR_FSL;
          FR_FSL: st_q <= FR_LO;
          FR_LO: begin
            st_q <= FR_HI;
            sh_q <= sh_q << 1;
          end
          FR_HI: begin
            if (bcnt_q == BIT_CW'(WORD_W - 1)) st_q <= FR_TAIL;
            else begin
              bcnt_q <= bcnt_q + 1'b1;
              st_q   <= FR_LO;
            end
          end
          default: begin
            st_q   <= FR_IDLE;
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  // R6: frame sync falls only after chip select has been low a phase
  a_r6_cs_leads_fs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs) |-> (!cs_n && $past(!cs_n)));
  // R6: chip select rises only after frame sync has returned high
  a_r6_fs_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(fs));
  // R7: data is steady across each receiving (falling) clock edge
  a_r7_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> $stable(sdo));
  // R10: end-of-frame marker lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/wavefeed_ser.sv
module wavefeed_ser
  import wf_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] tick_period,
  input  logic             wave_sel,
  input  logic [3:0]       ctrl_nib,
  input  logic [DIV_W-1:0] sck_div,
  output logic             cs_n,
  output logic             fs,
  output logic             sck,
  output logic             sdo,
  output logic             frame_done
);
  logic              tick;
  logic              busy;
  logic              pend_q;
  logic              launch;
  logic [WORD_W-1:0] word;

  assign launch = !busy && (tick || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (launch) pend_q <= 1'b0;
    else if (tick)   pend_q <= 1'b1;
  end

  wf_tick_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(tick_period), .tick(tick)
  );

  wf_sample_gen u_gen (
    .clk(clk), .rst_n(rst_n), .adv(launch), .sel(wave_sel),
    .nib(NIB_W'(ctrl_nib)), .word(word)
  );

  wf_frame_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(launch), .word_in(word), .div(sck_div),
    .cs_n(cs_n), .fs(fs), .sck(sck), .sdo(sdo), .done(frame_done), .busy(busy)
  );

  // R9: a held tick starts the next frame in the first idle cycle
  a_r9_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy) |=> !cs_n);
  // R9: a held tick is never dropped while a frame is running
  a_r9_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && busy) |=> pend_q);
endmodule

// File: tb/sim_wavefeed_ser.sv
module sim_wavefeed_ser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tick_period = 16'd50;
  logic        wave_sel = 1'b0;
  logic [3:0]  ctrl_nib = 4'h0;
  logic [7:0]  sck_div = 8'd1;
  logic        cs_n, fs, sck, sdo, frame_done;

  always #10 clk = ~clk;

  wavefeed_ser u0 (
    .clk(clk), .rst_n(rst_n), .tick_period(tick_period), .wave_sel(wave_sel),
    .ctrl_nib(ctrl_nib), .sck_div(sck_div), .cs_n(cs_n), .fs(fs), .sck(sck),
    .sdo(sdo), .frame_done(frame_done)
  );

  // sine points written out from the requirement's formula
  localparam int SINE [32] = '{
    'h800, 'h990, 'hB10, 'hC70, 'hDA4, 'hEA4, 'hF60, 'hFD4,
    'hFFC, 'hFD4, 'hF60, 'hEA4, 'hDA4, 'hC70, 'hB10, 'h990,
    'h800, 'h670, 'h4F0, 'h390, 'h25C, 'h15C, 'h0A0, 'h02C,
    'h004, 'h02C, 'h0A0, 'h15C, 'h25C, 'h390, 'h4F0, 'h670};

  // vector: {sel, nib, div, period, frames}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 4'h4, 8'd1, 16'd50,  16'd6},
    {1'b1, 4'h0, 8'd2, 16'd100, 16'd40},
    {1'b0, 4'hF, 8'd3, 16'd20,  16'd5},
    {1'b1, 4'h9, 8'd0, 16'd0,   16'd10},
    {1'b0, 4'h0, 8'd5, 16'd300, 16'd3},
    {1'b1, 4'hA, 8'd1, 16'd37,  16'd8}};

  int n_chk = 0, n_bad = 0;
  int frames = 0, cyc = 0;
  int m_ramp = 0, m_ptr = 0;
  int exp_word = 0, exp_code = 0, got = 0, bits = 0;
  int low_cnt = 0, hi_cnt = 0, h = 1, last_fall = 0;
  int chk_mode = 0, skip = 0, last_ramp = -1;
  bit glitch = 0, first_after_rst = 1, wrap_seen = 0, f_sel = 0;
  logic prev_cs = 1, prev_sck = 1, prev_sdo = 0;
  logic sel_d = 0;
  logic [3:0] nib_d = 0;
  logic [7:0] div_d = 1;
  logic [15:0] per_d = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ramp = 0; m_ptr = 0; bits = 0; low_cnt = 0; hi_cnt = 0;
      first_after_rst = 1; prev_cs = 1; prev_sck = 1; last_ramp = -1;
    end else begin
      if (prev_cs && !cs_n) begin
        h = (div_d == 0) ? 1 : int'(div_d);
        f_sel = sel_d;
        if (sel_d) begin
          exp_code = SINE[m_ptr];
          m_ptr = (m_ptr + 1) % 32;
        end else begin
          m_ramp = (m_ramp + 4) % 4096;
          exp_code = m_ramp;
        end
        exp_word = int'(nib_d) * 4096 + exp_code;
        if (skip > 0) skip--;
        else if (chk_mode == 1) chk(hi_cnt == 1, "R9 idle gap between frames", hi_cnt, 1);
        else if (chk_mode == 2) chk(cyc - last_fall == int'(per_d) + 1, "R2 frame interval",
                                    cyc - last_fall, int'(per_d) + 1);
        last_fall = cyc; bits = 0; got = 0; low_cnt = 0; hi_cnt = 0; glitch = 0;
      end
      if (!cs_n) low_cnt++; else hi_cnt++;
      if (!cs_n && !fs && prev_sck && !sck) begin
        got = got * 2 + int'(sdo);
        bits++;
      end
      if (!cs_n && !sck && !prev_sck && sdo !== prev_sdo) glitch = 1;
      if (!fs && cs_n) chk(0, "R6 fs low outside cs", int'(fs), 1);
      if (frame_done) begin
        chk(got == exp_word, "R3 R4 R5 R11 word", got, exp_word);
        if (first_after_rst)
          chk((got % 4096) == (f_sel ? 'h800 : 'h004), "R1 first sample", got % 4096,
              f_sel ? 'h800 : 'h004);
        first_after_rst = 0;
        chk(bits == 16 && !glitch, "R7 bit count and data steadiness", bits, 16);
        chk(low_cnt == 35 * h, "R8 frame length", low_cnt, 35 * h);
        chk(cs_n && fs && sck, "R10 done with idle lines", {cs_n, fs, sck}, 7);
        if (!f_sel) begin
          if (last_ramp == 'hFFC && (got % 4096) == 0) wrap_seen = 1;
          last_ramp = got % 4096;
        end
        frames++;
      end
      prev_cs = cs_n; prev_sck = sck; prev_sdo = sdo;
    end
    sel_d = wave_sel; nib_d = ctrl_nib; div_d = sck_div; per_d = tick_period;
  end

  task automatic wait_frames(input int n);
    int t;
    t = frames + n;
    while (frames < t) @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic [3:0] nb, input logic [7:0] dv,
                       input logic [15:0] pr);
    @(posedge clk); #3;
    wave_sel = s; ctrl_nib = nb; sck_div = dv; tick_period = pr;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", frames);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle lines under reset
    chk(cs_n && fs && sck && !frame_done, "R1 reset levels", {cs_n, fs, sck, frame_done}, 'hE);
    @(posedge clk); #3 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][44], VEC[i][43:40], VEC[i][39:32], VEC[i][31:16]);
      wait_frames(int'(VEC[i][15:0]));
    end

    // R2: timer spacing when frames are short
    drive(1'b0, 4'h4, 8'd1, 16'd199);
    chk_mode = 2; skip = 2;
    wait_frames(6);

    // R9: ticks during a frame are held and merged
    chk_mode = 0;
    drive(1'b0, 4'h4, 8'd2, 16'd20);
    chk_mode = 1; skip = 2;
    wait_frames(6);

    // R3: full ramp wrap
    chk_mode = 0;
    drive(1'b0, 4'h0, 8'd0, 16'd0);
    wait_frames(1030);
    chk(wrap_seen, "R3 ramp wrap 0xFFC to 0x000", int'(wrap_seen), 1);

    // R1: reset in the middle of a frame
    drive(1'b1, 4'h4, 8'd3, 16'd10);
    wait_frames(1);
    while (cs_n) @(negedge clk);
    @(posedge clk); #3 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cs_n && fs && sck && !frame_done, "R1 reset mid-frame", {cs_n, fs, sck, frame_done}, 'hE);
    @(posedge clk); #3 rst_n = 1'b1;
    wait_frames(3);
    drive(1'b0, 4'h4, 8'd1, 16'd10);
    wait_frames(3);
    finish_run();
  end
endmodule